// File: doc/BRIEF.md
# Unsigned Saturate Execution Unit

This unit executes one unsigned-saturate instruction per accepted transfer in a 32-bit core with mixed 16/32-bit instruction encodings. Each transfer brings the 32-bit instruction word and the operand value already read from the source register. The unit decodes the word and shifts the operand by an amount and direction taken from the word. It then reads the shifted value as a signed 32-bit number and clamps it into the unsigned range 0 to 2^n-1, where n is a 5-bit bit-position field. The result, the destination index and a destination write-enable come out one cycle after acceptance. The unit also reports words that are not this instruction and register choices whose behaviour is undefined.

The source-register index is given combinationally from the offered word, so the register file can be read in the same cycle. Input and output use a valid/ready handshake. A word is accepted when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the output register is empty or is being drained in the same cycle, so a full, stalled output holds off new input. While `out_valid` is high and `out_ready` is low, every output field stays unchanged.

A sticky saturation flag is set by any accepted, writing instruction that clamps. Only reset clears it.

Top module: `usat_unit`

## Requirements
- R1: After reset `out_valid` and `q_flag` are 0 and `in_ready` is 1.
- R2: `rn_idx` equals word bits [19:16] combinationally. The registered `out_rd` equals bits [11:8] of the accepted word.
- R3: A word whose fixed bits differ from [31:27]=11110, [25:22]=1110, bit 20=0 and bit 15=0 raises `out_not_this`. So does a word with bit 21=1 and a zero shift amount. Either case holds `out_rd_we` and `out_sat` at 0.
- R4: An otherwise matching word raises `out_unpred` if either register index is 13 or 15, or if bit 26 or bit 5 is 1. `out_rd_we` and `out_sat` are then 0.
- R5: The shift amount is {bits[14:12], bits[7:6]}. Bit 21=0 selects a logical left shift (amount 0 leaves the value unchanged). Bit 21=1 selects an arithmetic right shift that copies bit 31 into the vacated bits.
- R6: With n = bits [4:0], the shifted value, read as signed, gives 0 if negative and 2^n-1 if above 2^n-1; any other value passes through unchanged. `out_sat` is 1 exactly when a writing instruction was clamped.
- R7: `q_flag` becomes 1 in the cycle after a writing instruction that clamps is accepted. It never returns to 0 without reset. A rejected or non-clamping instruction leaves it unchanged.
- R8: Output appears in the cycle after acceptance. `in_ready` = !`out_valid` or `out_ready`. While the output is stalled, all output fields hold their values and no new word is taken.
- R9: With n=6 and a left shift by 0: 0 gives 0, 10 gives 10 and 63 gives 63, none saturating, while 64 gives 63 saturating. With n=6, 32 shifted left by 1 gives 63 saturating. With n=8 and no shift, -10 gives 0 saturating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Offered word and operand are valid |
| in_ready | output | 1 | Unit can accept this cycle |
| in_insn | input | 32 | Instruction word |
| in_operand | input | 32 | Value of the source register |
| rn_idx | output | 4 | Source index decoded from `in_insn` |
| out_valid | output | 1 | Output register holds a result |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 32 | Clamped value |
| out_rd | output | 4 | Destination index |
| out_rd_we | output | 1 | Destination write enable |
| out_sat | output | 1 | This instruction clamped |
| out_not_this | output | 1 | Word is not this instruction |
| out_unpred | output | 1 | Register choice or reserved bit is undefined |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
Two functions can land in the same cycle. The sticky-flag update from a clamping instruction can coincide with a stall of the output register. The bench provokes this by accepting a saturating instruction while `out_ready` is low and holding the next word valid for several cycles. It judges the case by checking three things: `q_flag` rises once at acceptance, the held result and saturation bit do not move, and the waiting word is taken only when the consumer is ready again. Saturating operands sent with unpredictable or foreign encodings confirm that rejection wins over the flag update.

// File: rtl/usat_pkg.sv
package usat_pkg;
  localparam int XLEN  = 32;
  localparam int IDX_W = 4;
  localparam int AMT_W = 5;
  localparam int POS_W = 5;
  localparam logic [IDX_W-1:0] IDX_STACK = 4'd13;
  localparam logic [IDX_W-1:0] IDX_PCNT  = 4'd15;

  typedef struct packed {
    logic [IDX_W-1:0] rd;
    logic [IDX_W-1:0] rn;
    logic             asr;
    logic [AMT_W-1:0] amt;
    logic [POS_W-1:0] pos;
    logic             not_this;
    logic             unpred;
  } dec_t;
endpackage

// File: rtl/usat_decode.sv
module usat_decode
  import usat_pkg::*;
(
  input  logic [XLEN-1:0] insn,
  output dec_t            dec
);
  logic fixed_ok;
  logic bad_idx;

  always_comb begin
    fixed_ok = (insn[31:27] == 5'b11110) && (insn[25:22] == 4'b1110) &&
               !insn[20] && !insn[15];
    dec.rd  = insn[11:8];
    dec.rn  = insn[19:16];
    dec.asr = insn[21];
    dec.amt = {insn[14:12], insn[7:6]};
    dec.pos = insn[4:0];
    dec.not_this = !fixed_ok || (dec.asr && (dec.amt == '0));
    bad_idx = (dec.rd == IDX_STACK) || (dec.rd == IDX_PCNT) ||
              (dec.rn == IDX_STACK) || (dec.rn == IDX_PCNT);
    dec.unpred = !dec.not_this && (bad_idx || insn[26] || insn[5]);
  end
endmodule

// File: rtl/usat_shift.sv
module usat_shift #(
  parameter int W = 32,
  parameter int S = 5
) (
  input  logic [W-1:0] din,
  input  logic         asr,
  input  logic [S-1:0] amt,
  output logic [W-1:0] dout
);
  logic [W-1:0] stg [S+1];

  assign stg[0] = din;

  generate
    for (genvar i = 0; i < S; i++) begin : g_stage
      localparam int SH = 1 << i;
      logic [W-1:0] shl;
      logic [W-1:0] shr;
      assign shl = {stg[i][W-1-SH:0], {SH{1'b0}}};
      assign shr = {{SH{stg[i][W-1]}}, stg[i][W-1:SH]};
      assign stg[i+1] = amt[i] ? (asr ? shr : shl) : stg[i];
    end
  endgenerate

  assign dout = stg[S];
endmodule

// File: rtl/usat_clamp.sv
module usat_clamp #(
  parameter int W = 32,
  parameter int P = 5
) (
  input  logic [W-1:0] din,
  input  logic [P-1:0] pos,
  output logic [W-1:0] dout,
  output logic         sat
);
  logic [W-1:0] limit;

  always_comb begin
    limit = ({{(W-1){1'b0}}, 1'b1} << pos) - {{(W-1){1'b0}}, 1'b1};
    if (din[W-1]) begin
      dout = '0;
      sat  = 1'b1;
    end else if (din > limit) begin
      dout = limit;
      sat  = 1'b1;
    end else begin
      dout = din;
      sat  = 1'b0;
    end
  end
endmodule

// File: rtl/usat_unit.sv
module usat_unit
  import usat_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [XLEN-1:0]  in_insn,
  input  logic [XLEN-1:0]  in_operand,
  output logic [IDX_W-1:0] rn_idx,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [XLEN-1:0]  out_result,
  output logic [IDX_W-1:0] out_rd,
  output logic             out_rd_we,
  output logic             out_sat,
  output logic             out_not_this,
  output logic             out_unpred,
  output logic             q_flag
);
  dec_t            dec;
  logic [XLEN-1:0] shifted;
  logic [XLEN-1:0] clamped;
  logic            clip;
  logic            take;
  logic            writes;

  usat_decode u_dec (.insn(in_insn), .dec(dec));

  usat_shift #(.W(XLEN), .S(AMT_W)) u_shf (
    .din(in_operand), .asr(dec.asr), .amt(dec.amt), .dout(shifted)
  );

  usat_clamp #(.W(XLEN), .P(POS_W)) u_clp (
    .din(shifted), .pos(dec.pos), .dout(clamped), .sat(clip)
  );

  assign rn_idx   = dec.rn;
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;
  assign writes   = !dec.not_this && !dec.unpred;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid    <= 1'b0;
      out_result   <= '0;
      out_rd       <= '0;
      out_rd_we    <= 1'b0;
      out_sat      <= 1'b0;
      out_not_this <= 1'b0;
      out_unpred   <= 1'b0;
      q_flag       <= 1'b0;
    end else if (take) begin
      out_valid    <= 1'b1;
      out_result   <= clamped;
      out_rd       <= dec.rd;
      out_rd_we    <= writes;
      out_sat      <= writes && clip;
      out_not_this <= dec.not_this;
      out_unpred   <= dec.unpred;
      q_flag       <= q_flag || (writes && clip);
    end else if (out_ready) begin
      out_valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/usat_unit_chk.sv
module usat_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_result,
  input logic        out_sat,
  input logic        q_flag
);
  assert_q_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(q_flag));

  assert_q_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(q_flag) |-> (out_valid && out_sat));

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_sat)));

  assert_sat_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sat) |-> ($countones(out_result + 32'd1) == 1));

  assert_ready_after_drain_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);
endmodule

bind usat_unit usat_unit_chk u_chk (.*);

// File: tb/usat_unit_bench.sv
module usat_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [31:0] in_insn = '0;
  logic [31:0] in_operand = '0;
  logic [3:0]  rn_idx;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [31:0] out_result;
  logic [3:0]  out_rd;
  logic        out_rd_we, out_sat, out_not_this, out_unpred, q_flag;

  int checks = 0;
  int fails  = 0;
  bit q_model = 0;
  bit done = 0;

  always #5 clk = ~clk;

  usat_unit u_usat_unit (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(input logic [3:0] rd, input logic [3:0] rn,
                                     input logic sh, input logic [4:0] amt, input logic [4:0] n);
    return {5'b11110, 1'b0, 4'b1110, sh, 1'b0, rn, 1'b0, amt[4:2], rd, amt[1:0], 1'b0, n};
  endfunction

  task automatic model(input logic [31:0] w, input logic [31:0] op,
                       output logic [31:0] res, output bit sat, output bit nt, output bit up);
    logic [4:0]  amt;
    logic [31:0] v;
    logic [31:0] lim;
    amt = {w[14:12], w[7:6]};
    nt = !(w[31:27] == 5'b11110 && w[25:22] == 4'b1110 && !w[20] && !w[15]) ||
         (w[21] && amt == 0);
    up = !nt && (w[19:16] == 13 || w[19:16] == 15 || w[11:8] == 13 || w[11:8] == 15 ||
                 w[26] || w[5]);
    v = w[21] ? 32'($signed(op) >>> amt) : (op << amt);
    lim = 32'((64'd1 << w[4:0]) - 64'd1);
    if ($signed(v) < 0) begin res = 0; sat = 1; end
    else if (v > lim) begin res = lim; sat = 1; end
    else begin res = v; sat = 0; end
  endtask

  task automatic run_op(input logic [31:0] w, input logic [31:0] op);
    logic [31:0] er;
    bit es, ent, eup, ewe;
    @(negedge clk);
    in_insn = w; in_operand = op; in_valid = 1'b1;
    #1;
    chk(rn_idx == w[19:16], "R2 rn_idx", {28'd0, rn_idx}, {28'd0, w[19:16]});
    chk(in_ready, "R8 ready idle", {31'd0, in_ready}, 32'd1);
    @(negedge clk);
    in_valid = 1'b0;
    model(w, op, er, es, ent, eup);
    ewe = !ent && !eup;
    chk(out_valid, "R8 latency", {31'd0, out_valid}, 32'd1);
    chk(out_not_this == ent, "R3 not_this", {31'd0, out_not_this}, {31'd0, ent});
    chk(out_unpred == eup, "R4 unpred", {31'd0, out_unpred}, {31'd0, eup});
    chk(out_rd_we == ewe, "R3/R4 we", {31'd0, out_rd_we}, {31'd0, ewe});
    chk(out_rd == w[11:8], "R2 rd", {28'd0, out_rd}, {28'd0, w[11:8]});
    if (ewe) chk(out_result == er, "R5/R6 result", out_result, er);
    chk(out_sat == (ewe && es), "R6 sat", {31'd0, out_sat}, {31'd0, ewe && es});
    q_model = q_model | (ewe && es);
    chk(q_flag == q_model, "R7 q_flag", {31'd0, q_flag}, {31'd0, q_model});
  endtask

  task automatic vec(input logic [31:0] w, input logic [31:0] op,
                     input logic [31:0] er, input bit es);
    run_op(w, op);
    chk(out_result == er, "R9 vector result", out_result, er);
    chk(out_sat == es, "R9 vector sat", {31'd0, out_sat}, {31'd0, es});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [4:0]  amts [5] = '{5'd0, 5'd1, 5'd7, 5'd16, 5'd31};
    logic [31:0] ops  [6] = '{32'h0000_0000, 32'h7FFF_FFFF, 32'h8000_0000,
                              32'hFFFF_FFFF, 32'h0000_0005, 32'h0001_2345};
    logic [31:0] held;
    repeat (3) @(negedge clk);
    chk(!out_valid, "R1 out_valid", {31'd0, out_valid}, 32'd0);
    chk(!q_flag, "R1 q_flag", {31'd0, q_flag}, 32'd0);
    chk(in_ready, "R1 in_ready", {31'd0, in_ready}, 32'd1);
    rst_n = 1'b1;

    // R9 non-saturating vectors
    vec(mk(4'd1, 4'd2, 1'b0, 5'd0, 5'd6), 32'd0,  32'd0,  1'b0);
    vec(mk(4'd1, 4'd2, 1'b0, 5'd0, 5'd6), 32'd10, 32'd10, 1'b0);
    vec(mk(4'd1, 4'd2, 1'b0, 5'd0, 5'd6), 32'd63, 32'd63, 1'b0);

    // R4: saturating operand, unpredictable registers and reserved bits, Q untouched
    run_op(mk(4'd13, 4'd2, 1'b0, 5'd0, 5'd6), 32'd64);
    run_op(mk(4'd1, 4'd15, 1'b0, 5'd0, 5'd6), 32'd64);
    run_op(mk(4'd1, 4'd2, 1'b0, 5'd0, 5'd6) | 32'h0400_0000, 32'd64);
    run_op(mk(4'd1, 4'd2, 1'b0, 5'd0, 5'd6) | 32'h0000_0020, 32'd64);
    // R3: foreign encodings and arithmetic shift by zero
    run_op(mk(4'd1, 4'd2, 1'b1, 5'd0, 5'd6), 32'hFFFF_FFFF);
    run_op(mk(4'd1, 4'd2, 1'b0, 5'd0, 5'd6) | 32'h0010_0000, 32'd64);
    run_op(mk(4'd1, 4'd2, 1'b0, 5'd0, 5'd6) ^ 32'h8000_0000, 32'd64);
    chk(!q_flag, "R7 q kept by rejected ops", {31'd0, q_flag}, 32'd0);

    // R8 + R7: saturating op accepted while output stalls
    @(negedge clk);
    out_ready = 1'b0;
    in_insn = mk(4'd3, 4'd4, 1'b0, 5'd0, 5'd6); in_operand = 32'd64; in_valid = 1'b1;
    @(negedge clk);
    in_insn = mk(4'd5, 4'd6, 1'b0, 5'd0, 5'd3); in_operand = 32'd2;
    chk(q_flag, "R7 q set on accept", {31'd0, q_flag}, 32'd1);
    chk(out_result == 32'd63 && out_sat, "R9 64 n6 saturates", out_result, 32'd63);
    chk(!in_ready, "R8 ready low when stalled", {31'd0, in_ready}, 32'd0);
    held = out_result;
    repeat (2) @(negedge clk);
    chk(out_result == held && out_rd == 4'd3, "R8 hold while stalled", out_result, held);
    chk(out_sat, "R8 sat held", {31'd0, out_sat}, 32'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_result == 32'd2 && out_rd == 4'd5 && !out_sat, "R8 waiting word taken",
        out_result, 32'd2);
    chk(q_flag, "R7 q stays set", {31'd0, q_flag}, 32'd1);
    q_model = 1;
    @(negedge clk);
    chk(!out_valid, "R8 drained", {31'd0, out_valid}, 32'd0);

    vec(mk(4'd1, 4'd2, 1'b0, 5'd1, 5'd6), 32'd32, 32'd63, 1'b1);
    vec(mk(4'd1, 4'd2, 1'b0, 5'd0, 5'd8), 32'hFFFF_FFF6, 32'd0, 1'b1);

    // R5/R6 sweep of bit positions, shift kinds, amounts and boundary operands
    for (int n = 0; n < 32; n++)
      for (int sh = 0; sh < 2; sh++)
        for (int a = 0; a < 5; a++)
          for (int o = 0; o < 6; o++)
            run_op(mk(4'(n % 13), 4'((n + 3) % 13), 1'(sh), amts[a], 5'(n)), ops[o]);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule